// File: doc/BRIEF.md
# Ripple-Flag Two's Complement Negator

This block returns the arithmetic negation of an unsigned word in two's complement form, without any adder or incrementer. Starting at the least significant bit, a single flag travels upward and records whether any lower bit was a 1. Every bit at or below the lowest set bit passes through unchanged. Every bit above it is inverted. This gives the same result as inverting the word and adding one, but the only chain in the logic is the flag, with one select stage per bit.

Each bit position above bit zero is a small cell with two 2:1 selects. The first select, steered by the incoming flag, picks either the true or the inverted data bit. The second select, steered by the same flag, either forces the outgoing flag to 1 or passes the data bit on as the new flag. The top position has no following bit, so it carries only the data select.

An output register may be kept or removed with a parameter. With the register in place, a synchronous active-high reset clears the output and the result appears one clock after the input is sampled.

Top module: `twos_negator`

## Requirements
- R1: Output bit 0 always equals input bit 0 of the sampled word.
- R2: For any bit position above the lowest 1 in the input, the output bit is the inverse of the input bit.
- R3: For every bit position at or below the lowest 1 in the input, the output bit equals the input bit. Once any lower bit is 1, the flag stays at 1 for all higher positions.
- R4: The most significant output bit equals the top input bit XOR (any of the lower input bits is 1). No flag is produced beyond the top bit.
- R5: Input 8'b10010000 yields 8'b01110000, and input 8'b10010001 yields 8'b01101111.
- R6: Input 8'b00000000 yields 8'b00000000, and input 8'b10000000 yields 8'b10000000.
- R7: For every 8-bit input x, the output equals (256 - x) mod 256.
- R8: With the output register enabled (the default), data_out shows the result for the data_in value sampled on the previous rising clock edge.
- R9: While rst is high at a rising edge, data_out becomes 8'h00 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | WIDTH (8) | Word to negate |
| data_out | output | WIDTH (8) | Two's complement negation of data_in |

## Verification
The bench sweeps all 256 inputs and also drives the two stated example words. The zero word matters because the flag never rises, so a design that inverts by default would return all ones. The word 8'h80 matters because it negates to itself, so a design that mishandles the top cell flips its sign bit. The word 8'h01 and odd words in general expose a design that drops the LSB pass-through or lets the flag fire one position late, which would invert bit 1 wrongly. Separate per-bit checks at and above the lowest set bit show whether the copy region ends at the right place. A reset asserted while the input is nonzero shows whether the output register really clears.

// File: rtl/negate_pkg.sv
package negate_pkg;
  localparam int unsigned NEG_DEFAULT_WIDTH = 8;
  localparam bit          NEG_DEFAULT_OUTREG = 1'b1;
endpackage

// File: rtl/negate_cell.sv
// One bit position: a data select (true / inverted) and a flag-forward select.
module negate_cell (
  input  logic d,
  input  logic flag_in,
  output logic q,
  output logic flag_out
);
  always_comb begin
    if (flag_in) q = ~d;
    else         q = d;
  end

  always_comb begin
    if (flag_in) flag_out = 1'b1;
    else         flag_out = d;
  end
endmodule

// File: rtl/negate_chain.sv
// Ripple chain of cells; the top position keeps only its data select.
module negate_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-2:0] seen;

  assign data_out[0] = data_in[0];
  assign seen[0]     = data_in[0];

  genvar i;
  generate
    for (i = 1; i < TOP; i++) begin : g_cell
      negate_cell u_cell (
        .d        (data_in[i]),
        .flag_in  (seen[i-1]),
        .q        (data_out[i]),
        .flag_out (seen[i])
      );
    end
  endgenerate

  always_comb begin
    if (seen[TOP-1]) data_out[TOP] = ~data_in[TOP];
    else             data_out[TOP] = data_in[TOP];
  end

  // R3: a zero word leaves the flag low everywhere, so nothing is inverted
  always_comb begin
    if (data_in == '0) begin
      zero_copy_chk: assert (data_out == '0);
    end
  end
endmodule

// File: rtl/negate_outreg.sv
// Optional output stage: synchronous active-high reset register or a wire.
module negate_outreg #(
  parameter int unsigned WIDTH  = 8,
  parameter bit          ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (ENABLE) begin : g_reg
      logic [WIDTH-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/twos_negator.sv
module twos_negator
  import negate_pkg::*;
#(
  parameter int unsigned WIDTH  = NEG_DEFAULT_WIDTH,
  parameter bit          OUTREG = NEG_DEFAULT_OUTREG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] neg_comb;

  negate_chain #(.WIDTH(WIDTH)) u_chain (
    .data_in  (data_in),
    .data_out (neg_comb)
  );

  negate_outreg #(.WIDTH(WIDTH), .ENABLE(OUTREG)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (neg_comb),
    .q   (data_out)
  );

  generate
    if (OUTREG) begin : g_chk
      logic [WIDTH-1:0] one_w;
      assign one_w = {{(WIDTH-1){1'b0}}, 1'b1};

      // R9
      reset_clear_chk: assert property (@(posedge clk) rst |=> data_out == '0);

      // R7 R8
      negate_value_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> data_out == WIDTH'((~$past(data_in)) + one_w));

      // R1
      lsb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> data_out[0] == $past(data_in[0]));

      // R4
      top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> data_out[TOP] == ($past(data_in[TOP]) ^ ($past(data_in[TOP-1:0]) != '0)));

      // R6
      zero_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && data_in == '0) |=> data_out == '0);
    end
  endgenerate
endmodule

// File: tb/sim_twos_negator.sv
module sim_twos_negator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  int hist[$];

  always #4 clk = ~clk;

  twos_negator u0 (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .data_out (data_out)
  );

  task automatic expect8(input string req, input int actual, input int exp_v);
    checks++;
    if (actual != exp_v) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, actual, exp_v);
    end
  endtask

  task automatic check_word(input int v);
    int low;
    if (v < 0) begin
      expect8("R9", int'(data_out), 0);
      return;
    end
    expect8("R7 R8", int'(data_out), (256 - v) % 256);
    if (v == 8'h90) expect8("R5", int'(data_out), 8'h70);
    if (v == 8'h91) expect8("R5", int'(data_out), 8'h6F);
    if (v == 0)     expect8("R6", int'(data_out), 0);
    if (v == 8'h80) expect8("R6", int'(data_out), 8'h80);
    expect8("R1", int'(data_out[0]), v % 2);
    expect8("R4", int'(data_out[7]), ((v >> 7) & 1) ^ ((v % 128) != 0 ? 1 : 0));
    low = 8;
    for (int b = 7; b >= 0; b--) if (((v >> b) & 1) == 1) low = b;
    for (int b = 0; b < 8; b++) begin
      if (b <= low) expect8("R3", int'(data_out[b]), (v >> b) & 1);
      else          expect8("R2", int'(data_out[b]), 1 - ((v >> b) & 1));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) hist.push_back(-1);
    else     hist.push_back(int'(data_in));
  end

  always @(negedge clk) begin
    if (!done && hist.size() > 0) check_word(hist.pop_front());
  end

  task automatic drive(input int v);
    @(negedge clk);
    data_in = v[7:0];
  endtask

  initial begin
    int seeds[7] = '{8'h90, 8'h91, 8'h00, 8'h80, 8'h01, 8'hFF, 8'h7F};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    foreach (seeds[k]) drive(seeds[k]);
    for (int v = 0; v < 256; v++) drive(v);
    @(negedge clk);
    data_in = 8'hAA;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(8'h90);
    drive(8'h91);
    drive(8'h02);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule